// File: doc/BRIEF.md
# Dual-Section Truth-Table Command Controller

This block is the host-side command controller for a two-section programmable logic unit sitting on a crate dataway bus. Each section owns a 256-word by 8-bit truth table, an 8-bit pattern register that captures the input word, and a set of latched continuous-mode outputs. The controller decodes a 5-bit function code and a 4-bit sub-address that the bus holds steady across two strobe phases, first S1 and then S2. It also acts on the global initialise (Z) and clear (C) lines. It answers with the accepted (X) and status (Q) responses and drives a 16-bit read bus.

Each section has its own 9-bit address counter. The low eight bits address the truth table and bit 8 marks overflow. A host fills or dumps a whole table with 256 auto-incrementing commands, and Q dropping tells it that the counter has run past the last word. Random access loads the counter from the upper half of the write bus. The logic sections themselves are outside this block. They appear only as table write and read ports, pattern inputs, and clear strobes.

Responses and clear or write strobes are combinational within the strobe cycle. Counter updates take effect at the clock edge that closes the strobe cycle. The section index is sub-address bit 0 (0 selects the first section), and sub-address bit 1 selects the table/address operations over the pattern operations.

Top module: `dwCmdTop`

## Requirements
- R1: While initZ or clearC is high, patClr0, patClr1, outClr0 and outClr1 are all high, no table write strobe is issued, and both address counters are 0 after that clock edge.
- R2: xResp is 1 exactly when fnCode is one of 0, 2, 9, 16, 18 and subAddr is 0 to 3. Any other combination gives xResp=0, qResp=0 and rData=0, and with strobes it produces no clear, write or counter change.
- R3: qResp equals xResp, except for single-section table functions (fnCode 0 or 2 with subAddr 2/3, fnCode 16 with subAddr 0..3, fnCode 18 with subAddr 0/1): for these, qResp is 0 when bit 8 of the selected counter is set.
- R4: fnCode 0 or 2 with subAddr 0/1 puts the selected section's pattern on rData[7:0], with rData[15:8]=0.
- R5: fnCode 0 or 2 with subAddr 2/3 puts the table word at the selected counter on rData[7:0] and the counter's low 8 bits on rData[15:8].
- R6: fnCode 2 at S2 pulses patClr and outClr of the selected section for subAddr 0/1, and increments the selected counter for subAddr 2/3.
- R7: fnCode 9 at S2 pulses patClr and outClr of the selected section for subAddr 0/1, and sets both counters to 0 for subAddr 2/3.
- R8: fnCode 16 with subAddr 0/1 writes wData[7:0] into the selected table at the counter address at S2 and leaves the counter unchanged.
- R9: fnCode 16 with subAddr 2/3 loads the selected counter from wData[15:8] (bit 8 cleared) at S1, and writes wData[7:0] at that address at S2.
- R10: fnCode 18 with subAddr 0/1 writes wData[7:0] at the counter address at S1 and increments the counter at S2.
- R11: fnCode 18 with subAddr 2/3 loads both counters from wData[15:8] at S1.
- R12: An increment from 255 sets bit 8 and leaves the low bits at 0. An overflowed counter holds under further increments, and no table write is issued while it is overflowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fnCode | input | 5 | Function code |
| subAddr | input | 4 | Sub-address |
| s1 | input | 1 | First strobe phase, one cycle |
| s2 | input | 1 | Second strobe phase, one cycle |
| initZ | input | 1 | Global initialise |
| clearC | input | 1 | Global clear |
| wData | input | 16 | Write bus: [7:0] data, [15:8] address |
| rData | output | 16 | Read bus |
| xResp | output | 1 | Command accepted |
| qResp | output | 1 | Status response |
| patIn0 | input | 8 | Pattern register of section 0 |
| patIn1 | input | 8 | Pattern register of section 1 |
| patClr0 | output | 1 | Clear pattern register of section 0 |
| patClr1 | output | 1 | Clear pattern register of section 1 |
| outClr0 | output | 1 | Clear continuous outputs of section 0 |
| outClr1 | output | 1 | Clear continuous outputs of section 1 |
| tblAddr0 | output | 8 | Table address of section 0 |
| tblAddr1 | output | 8 | Table address of section 1 |
| tblWe0 | output | 1 | Table write strobe of section 0 |
| tblWe1 | output | 1 | Table write strobe of section 1 |
| tblWdata | output | 8 | Table write data |
| tblRdata0 | input | 8 | Table read data of section 0 |
| tblRdata1 | input | 8 | Table read data of section 1 |

## Verification
The assertions check the following on every cycle:
- Counter arithmetic: clear, load, a single-step increment, and holding once overflowed.
- Global initialise and clear forcing all clears and zeroing both counters.
- No table write reaching an overflowed counter.
- Q never standing without X.
- Unsupported codes staying quiet.

The bench scenarios cover the rest:
- A full 256-word fill and dump of each table, where Q must drop at the 257th step.
- The exact strobe phase at which each function writes, clears or moves a counter.
- Read-bus contents across every function and sub-address pair.

// File: rtl/dwCmdPkg.sv
package dwCmdPkg;
  localparam int NSEC = 2;
  localparam int F_W  = 5;
  localparam int A_W  = 4;

  localparam logic [F_W-1:0] FN_READ     = 5'd0;
  localparam logic [F_W-1:0] FN_READCLR  = 5'd2;
  localparam logic [F_W-1:0] FN_CLEAR    = 5'd9;
  localparam logic [F_W-1:0] FN_WRITE    = 5'd16;
  localparam logic [F_W-1:0] FN_WRITEINC = 5'd18;

  typedef enum logic [1:0] {RD_NONE, RD_PAT, RD_TBL} dwRdSel_t;

  typedef struct packed {
    logic [NSEC-1:0] cntClr;
    logic [NSEC-1:0] cntLoad;
    logic [NSEC-1:0] cntInc;
    logic [NSEC-1:0] tblWe;
    logic [NSEC-1:0] patClr;
    logic [NSEC-1:0] outClr;
  } dwStrobe_t;
endpackage

// File: rtl/dwAddrCounter.sv
module dwAddrCounter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              ld,
  input  logic              inc,
  input  logic [ADDR_W-1:0] ldVal,
  output logic [ADDR_W:0]   cnt
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (ld)          cnt <= {1'b0, ldVal};
    else if (inc && !cnt[ADDR_W]) cnt <= cnt + 1'b1;
  end

  // R7 / R1: clear goes to word 0
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> cnt == '0);
  // R9 / R11: load takes the write-bus address with overflow cleared
  a_r9_load_value: assert property (@(posedge clk) disable iff (!rstN)
    (ld && !clr) |=> cnt == {1'b0, $past(ldVal)});
  // R10 / R6: one step per increment
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && !ld && !cnt[ADDR_W]) |=> cnt == $past(cnt) + 1'b1);
  // R12: overflowed counter holds
  a_r12_ovf_hold: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && !ld && cnt[ADDR_W]) |=> $stable(cnt));
endmodule

// File: rtl/dwCmdCtrl.sv
module dwCmdCtrl
  import dwCmdPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [F_W-1:0]  fnCode,
  input  logic [A_W-1:0]  subAddr,
  input  logic            s1,
  input  logic            s2,
  input  logic            initZ,
  input  logic            clearC,
  input  logic [NSEC-1:0] ovf,
  output dwStrobe_t       st,
  output dwRdSel_t        rdSel,
  output logic            sec,
  output logic            xResp,
  output logic            qResp
);
  logic hiA;
  logic memFn;
  logic zc;

  assign sec = subAddr[0];
  assign hiA = subAddr[1];
  assign zc  = initZ | clearC;

  always_comb begin
    st    = '0;
    xResp = 1'b0;
    memFn = 1'b0;
    rdSel = RD_NONE;
    if (subAddr[A_W-1:2] == '0) begin
      case (fnCode)
        FN_READ, FN_READCLR: begin
          xResp = 1'b1;
          memFn = hiA;
          rdSel = hiA ? RD_TBL : RD_PAT;
          if (fnCode == FN_READCLR && s2) begin
            if (hiA) st.cntInc[sec] = 1'b1;
            else begin
              st.patClr[sec] = 1'b1;
              st.outClr[sec] = 1'b1;
            end
          end
        end
        FN_CLEAR: begin
          xResp = 1'b1;
          if (s2) begin
            if (hiA) st.cntClr = '1;
            else begin
              st.patClr[sec] = 1'b1;
              st.outClr[sec] = 1'b1;
            end
          end
        end
        FN_WRITE: begin
          xResp = 1'b1;
          memFn = 1'b1;
          if (hiA && s1) st.cntLoad[sec] = 1'b1;
          if (s2)        st.tblWe[sec]   = 1'b1;
        end
        FN_WRITEINC: begin
          xResp = 1'b1;
          if (!hiA) begin
            memFn = 1'b1;
            if (s1) st.tblWe[sec]  = 1'b1;
            if (s2) st.cntInc[sec] = 1'b1;
          end else if (s1) begin
            st.cntLoad = '1;
          end
        end
        default: ;
      endcase
    end
    st.tblWe = st.tblWe & ~ovf;
    if (zc) begin
      st        = '0;
      st.cntClr = '1;
      st.patClr = '1;
      st.outClr = '1;
    end
    qResp = xResp & ~(memFn & ovf[sec]);
  end

  // R3: status never stands without acceptance
  a_r3_q_needs_x: assert property (@(posedge clk) disable iff (!rstN)
    qResp |-> xResp);
  // R2: unsupported codes raise no strobe
  a_r2_unsupported_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!xResp && !zc) |-> (st == '0 && rdSel == RD_NONE));
endmodule

// File: rtl/dwCmdData.sv
module dwCmdData
  import dwCmdPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int BUS_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwStrobe_t         st,
  input  dwRdSel_t          rdSel,
  input  logic              sec,
  input  logic [BUS_W-1:0]  wData,
  input  logic [DATA_W-1:0] patIn0,
  input  logic [DATA_W-1:0] patIn1,
  input  logic [DATA_W-1:0] tblRdata0,
  input  logic [DATA_W-1:0] tblRdata1,
  output logic [NSEC-1:0]   ovf,
  output logic [ADDR_W-1:0] tblAddr0,
  output logic [ADDR_W-1:0] tblAddr1,
  output logic [BUS_W-1:0]  rData
);
  logic [ADDR_W:0]   cnt   [NSEC];
  logic [DATA_W-1:0] patArr[NSEC];
  logic [DATA_W-1:0] rdArr [NSEC];

  assign patArr[0] = patIn0;
  assign patArr[1] = patIn1;
  assign rdArr[0]  = tblRdata0;
  assign rdArr[1]  = tblRdata1;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    dwAddrCounter #(.ADDR_W(ADDR_W)) cnt_i (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (st.cntClr[i]),
      .ld    (st.cntLoad[i]),
      .inc   (st.cntInc[i]),
      .ldVal (wData[BUS_W-1:DATA_W]),
      .cnt   (cnt[i])
    );
    assign ovf[i] = cnt[i][ADDR_W];

    // R12: no table write into an overflowed counter
    a_r12_no_ovf_write: assert property (@(posedge clk) disable iff (!rstN)
      st.tblWe[i] |-> !cnt[i][ADDR_W]);
  end

  assign tblAddr0 = cnt[0][ADDR_W-1:0];
  assign tblAddr1 = cnt[1][ADDR_W-1:0];

  always_comb begin
    case (rdSel)
      RD_PAT:  rData = {{ADDR_W{1'b0}}, patArr[sec]};
      RD_TBL:  rData = {cnt[sec][ADDR_W-1:0], rdArr[sec]};
      default: rData = '0;
    endcase
  end
endmodule

// File: rtl/dwCmdTop.sv
module dwCmdTop
  import dwCmdPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int BUS_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [F_W-1:0]    fnCode,
  input  logic [A_W-1:0]    subAddr,
  input  logic              s1,
  input  logic              s2,
  input  logic              initZ,
  input  logic              clearC,
  input  logic [BUS_W-1:0]  wData,
  output logic [BUS_W-1:0]  rData,
  output logic              xResp,
  output logic              qResp,
  input  logic [DATA_W-1:0] patIn0,
  input  logic [DATA_W-1:0] patIn1,
  output logic              patClr0,
  output logic              patClr1,
  output logic              outClr0,
  output logic              outClr1,
  output logic [ADDR_W-1:0] tblAddr0,
  output logic [ADDR_W-1:0] tblAddr1,
  output logic              tblWe0,
  output logic              tblWe1,
  output logic [DATA_W-1:0] tblWdata,
  input  logic [DATA_W-1:0] tblRdata0,
  input  logic [DATA_W-1:0] tblRdata1
);
  dwStrobe_t       st;
  dwRdSel_t        rdSel;
  logic            sec;
  logic [NSEC-1:0] ovf;

  dwCmdCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .fnCode(fnCode), .subAddr(subAddr),
    .s1(s1), .s2(s2), .initZ(initZ), .clearC(clearC), .ovf(ovf),
    .st(st), .rdSel(rdSel), .sec(sec), .xResp(xResp), .qResp(qResp)
  );

  dwCmdData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) data_i (
    .clk(clk), .rstN(rstN), .st(st), .rdSel(rdSel), .sec(sec),
    .wData(wData), .patIn0(patIn0), .patIn1(patIn1),
    .tblRdata0(tblRdata0), .tblRdata1(tblRdata1), .ovf(ovf),
    .tblAddr0(tblAddr0), .tblAddr1(tblAddr1), .rData(rData)
  );

  assign patClr0  = st.patClr[0];
  assign patClr1  = st.patClr[1];
  assign outClr0  = st.outClr[0];
  assign outClr1  = st.outClr[1];
  assign tblWe0   = st.tblWe[0];
  assign tblWe1   = st.tblWe[1];
  assign tblWdata = wData[DATA_W-1:0];

  // R1: global initialise/clear forces all clears and blocks writes
  a_r1_zc_clears: assert property (@(posedge clk) disable iff (!rstN)
    (initZ || clearC) |-> (patClr0 && patClr1 && outClr0 && outClr1 && !tblWe0 && !tblWe1));
  // R1: both counters at word 0 afterwards
  a_r1_zc_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (initZ || clearC) |=> (tblAddr0 == '0 && tblAddr1 == '0 && qResp == xResp));
endmodule

// File: tb/dwCmdTop_tb.sv
`timescale 1ns/1ps
module dwCmdTop_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  fnCode = '0;
  logic [3:0]  subAddr = '0;
  logic        s1 = 1'b0, s2 = 1'b0, initZ = 1'b0, clearC = 1'b0;
  logic [15:0] wData = '0;
  logic [15:0] rData;
  logic        xResp, qResp;
  logic [7:0]  patIn0 = 8'hA5, patIn1 = 8'h3C;
  logic        patClr0, patClr1, outClr0, outClr1, tblWe0, tblWe1;
  logic [7:0]  tblAddr0, tblAddr1, tblWdata, tblRdata0, tblRdata1;

  logic [7:0] mem0 [256];
  logic [7:0] mem1 [256];

  int total = 0;
  int bad = 0;

  // observed strobes: {patClr1,patClr0,outClr1,outClr0,tblWe1,tblWe0}
  logic [5:0]  obs1, obs2;
  logic        q1, x1;
  logic [15:0] r1;

  always #2 clk = ~clk;

  dwCmdTop dut_i (
    .clk(clk), .rstN(rstN), .fnCode(fnCode), .subAddr(subAddr),
    .s1(s1), .s2(s2), .initZ(initZ), .clearC(clearC), .wData(wData),
    .rData(rData), .xResp(xResp), .qResp(qResp),
    .patIn0(patIn0), .patIn1(patIn1), .patClr0(patClr0), .patClr1(patClr1),
    .outClr0(outClr0), .outClr1(outClr1), .tblAddr0(tblAddr0), .tblAddr1(tblAddr1),
    .tblWe0(tblWe0), .tblWe1(tblWe1), .tblWdata(tblWdata),
    .tblRdata0(tblRdata0), .tblRdata1(tblRdata1)
  );

  always @(posedge clk) begin
    if (tblWe0) mem0[tblAddr0] <= tblWdata;
    if (tblWe1) mem1[tblAddr1] <= tblWdata;
  end
  assign tblRdata0 = mem0[tblAddr0];
  assign tblRdata1 = mem1[tblAddr1];

  function automatic logic [7:0] d0(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] d1(input int i);
    return 8'((i * 13 + 90) & 255);
  endfunction

  function automatic logic [5:0] strobes();
    return {patClr1, patClr0, outClr1, outClr0, tblWe1, tblWe0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doCmd(input logic [4:0] f, input logic [3:0] a, input logic [15:0] w);
    @(negedge clk);
    fnCode = f; subAddr = a; wData = w; s1 = 1'b1;
    #1;
    obs1 = strobes(); q1 = qResp; x1 = xResp; r1 = rData;
    @(negedge clk);
    s1 = 1'b0; s2 = 1'b1;
    #1;
    obs2 = strobes();
    @(negedge clk);
    s2 = 1'b0;
  endtask

  task automatic peek(input logic [4:0] f, input logic [3:0] a);
    @(negedge clk);
    fnCode = f; subAddr = a; wData = '0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem0[i] = 8'h00; mem1[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state (R2 / R5): counters at 0, idle read of table 0
    peek(5'd0, 4'd2);
    check("R5 reset addr/data", {xResp, qResp, rData}, {1'b1, 1'b1, 16'h0000});
    check("R2 reset no strobes", strobes(), 6'b0);

    // R10 / R12: fill both tables by auto-increment
    doCmd(5'd9, 4'd2, 16'h0);
    for (int i = 0; i < 256; i++) begin
      doCmd(5'd18, 4'd0, {8'h00, d0(i)});
      check("R10 fill s0 strobe S1", obs1, 6'b000001);
      check("R10 fill s0 Q", q1, 1'b1);
    end
    peek(5'd18, 4'd0);
    check("R12 R3 Q drops after overflow", {xResp, qResp, rData}, {1'b1, 1'b0, 16'h0});
    doCmd(5'd18, 4'd0, 16'h00FF);
    check("R12 no write while overflowed", {obs1, obs2}, 12'b0);
    for (int i = 0; i < 256; i++) doCmd(5'd18, 4'd1, {8'h00, d1(i)});
    peek(5'd0, 4'd3);
    check("R3 section1 Q low on overflow", {xResp, qResp}, 2'b10);
    peek(5'd0, 4'd0);
    check("R3 pattern read Q unaffected", {xResp, qResp}, 2'b11);

    // R7 / R6 / R5: reset counters and dump by read-and-increment
    doCmd(5'd9, 4'd3, 16'h0);
    for (int i = 0; i < 256; i++) begin
      doCmd(5'd2, 4'd2, 16'h0);
      check("R5 R6 dump s0", r1, {8'(i), d0(i)});
    end
    for (int i = 0; i < 256; i++) begin
      doCmd(5'd2, 4'd3, 16'h0);
      check("R5 R6 dump s1", r1, {8'(i), d1(i)});
    end
    peek(5'd0, 4'd2);
    check("R12 counter at overflow", {qResp, rData[15:8]}, {1'b0, 8'h00});
    doCmd(5'd2, 4'd2, 16'h0);
    peek(5'd0, 4'd2);
    check("R12 overflowed holds", {qResp, rData[15:8]}, {1'b0, 8'h00});

    // R2: exhaustive response sweep, counters reset first
    doCmd(5'd9, 4'd2, 16'h0);
    for (int f = 0; f < 32; f++) begin
      for (int a = 0; a < 16; a++) begin
        logic ex;
        logic [15:0] er;
        peek(5'(f), 4'(a));
        ex = (a < 4) && (f == 0 || f == 2 || f == 9 || f == 16 || f == 18);
        er = 16'h0;
        if (ex && (f == 0 || f == 2)) begin
          if (a == 0) er = {8'h00, patIn0};
          else if (a == 1) er = {8'h00, patIn1};
          else if (a == 2) er = {8'h00, d0(0)};
          else er = {8'h00, d1(0)};
        end
        check("R2 R4 R5 sweep", {xResp, qResp, rData}, {ex, ex, er});
      end
    end

    // R2: unsupported codes with strobes have no effect
    doCmd(5'd18, 4'd2, 16'h4400);
    doCmd(5'd1, 4'd0, 16'h55AA);  check("R2 f1 quiet", {x1, q1, obs1, obs2}, 14'b0);
    doCmd(5'd16, 4'd4, 16'h55AA); check("R2 f16 a4 quiet", {x1, q1, obs1, obs2}, 14'b0);
    doCmd(5'd18, 4'd7, 16'h55AA); check("R2 f18 a7 quiet", {x1, q1, obs1, obs2}, 14'b0);
    doCmd(5'd9, 4'd15, 16'h55AA); check("R2 f9 a15 quiet", {x1, q1, obs1, obs2}, 14'b0);
    doCmd(5'd2, 4'd8, 16'h55AA);  check("R2 f2 a8 quiet", {x1, q1, obs1, obs2}, 14'b0);
    peek(5'd0, 4'd2); check("R2 s0 addr kept", rData, {8'h44, d0(8'h44)});
    peek(5'd0, 4'd3); check("R2 s1 addr kept", rData, {8'h44, d1(8'h44)});

    // R11 + R8: load both, then write without increment
    doCmd(5'd18, 4'd3, 16'h2000);
    check("R11 load both strobes", {obs1, obs2}, 12'b0);
    doCmd(5'd16, 4'd0, 16'h00E7);
    check("R8 write at S2 only", {obs1, obs2}, {6'b000000, 6'b000001});
    peek(5'd0, 4'd2); check("R8 s0 data, addr unchanged", rData, 16'h20E7);
    peek(5'd0, 4'd3); check("R11 s1 addr loaded", rData, {8'h20, d1(8'h20)});

    // R9: random access load and write
    doCmd(5'd16, 4'd3, 16'h903C);
    check("R9 write at S2", {obs1, obs2}, {6'b000000, 6'b000010});
    peek(5'd0, 4'd3); check("R9 s1 addr+data", rData, 16'h903C);
    peek(5'd0, 4'd2); check("R9 s0 untouched", rData, 16'h20E7);

    // R6 / R7: pattern and output clears at S2
    doCmd(5'd2, 4'd0, 16'h0);
    check("R6 F2 A0 clears s0", {obs1, obs2}, {6'b000000, 6'b010100});
    check("R4 F2 A0 pattern", r1, {8'h00, patIn0});
    doCmd(5'd9, 4'd1, 16'h0);
    check("R7 F9 A1 clears s1", {obs1, obs2}, {6'b000000, 6'b101000});

    // R1: initialise and clear lines
    @(negedge clk); initZ = 1'b1; fnCode = 5'd16; subAddr = 4'd0; wData = 16'h0011; s2 = 1'b1;
    #1; check("R1 Z clears, blocks write", strobes(), 6'b111100);
    @(negedge clk); initZ = 1'b0; s2 = 1'b0;
    peek(5'd0, 4'd2); check("R1 Z s0 addr zero", rData[15:8], 8'h00);
    peek(5'd0, 4'd3); check("R1 Z s1 addr zero", rData[15:8], 8'h00);
    doCmd(5'd18, 4'd2, 16'h4400);
    @(negedge clk); clearC = 1'b1;
    #1; check("R1 C clears", strobes(), 6'b111100);
    @(negedge clk); clearC = 1'b0;
    peek(5'd0, 4'd3); check("R1 C s1 addr zero", {qResp, rData[15:8]}, {1'b1, 8'h00});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule